// File: doc/BRIEF.md
# Pan and Zoom Coordinate Mapper

This block turns a screen pixel position on a fixed 64 by 64 grid into a pair of fixed-point complex-plane coordinates for a fractal engine. The view is held as a real-axis origin, an imaginary-axis origin and a zoom level. Each output coordinate is the origin plus the pixel's signed distance from the grid centre, times a per-pixel step. The step is a power of two chosen by the zoom level, so the whole mapping is a shift and an add. No divider is needed, which a min/max window description would require.

Single-cycle pulses from already-debounced pan buttons move the origin by eight pixel steps at the current zoom. Panning therefore stays proportional to the magnification. Zoom pulses move the level between its limits. A fractal iteration core feeds the mapper its scan indices and takes the registered coordinates one cycle later.

All coordinates are signed Q4.12 values, 16 bits wide.

Top module: `pan_zoom_mapper`

## Requirements
- R1: While `rst` is high at a rising edge, both origins and the zoom level become 0, and both outputs read 0 after that edge.
- R2: On each rising edge without reset, `re_out` is loaded with ox + (pix_x − 32) × 2^−(4+L), and `im_out` is loaded with oy + (pix_y − 32) × 2^−(4+L). Here L is the zoom level and ox, oy are the origins held before that edge. Values are signed Q4.12 (12 fraction bits), so each output follows its index with one cycle of latency.
- R3: At level 0 with both origins 0, index 0 maps to −2.0 (0xE000), index 32 maps to 0x0000 and index 63 maps to +1.9375 (0x1F00).
- R4: A `pan_right` pulse adds 8 × 2^−(4+L) to ox and a `pan_left` pulse subtracts it. `pan_up` and `pan_down` do the same for oy. When both opposing pulses on one axis are high in the same cycle, that origin does not change.
- R5: A `zoom_in` pulse raises L by one, halving the step. A `zoom_out` pulse lowers L by one. When both are high in the same cycle, L does not change.
- R6: L stays within 0..8. A `zoom_in` pulse at level 8 is ignored, and so is a `zoom_out` pulse at level 0.
- R7: A pan pulse given in the same cycle as a zoom pulse moves the origin by the step of the level held before that edge. A view change first shows in the coordinate output for indices presented in the cycle after the pulse.
- R8: Origin updates and coordinate sums wrap modulo 2^16 (two's complement) and do not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 6 | Pixel column index 0..63 |
| pix_y | input | 6 | Pixel row index 0..63 |
| pan_up | input | 1 | Move imaginary origin up by one pan step |
| pan_down | input | 1 | Move imaginary origin down by one pan step |
| pan_left | input | 1 | Move real origin left by one pan step |
| pan_right | input | 1 | Move real origin right by one pan step |
| zoom_in | input | 1 | Raise zoom level (finer step) |
| zoom_out | input | 1 | Lower zoom level (coarser step) |
| re_out | output | 16 | Real coordinate, signed Q4.12, registered |
| im_out | output | 16 | Imaginary coordinate, signed Q4.12, registered |

## Verification
Each coordinate is due exactly one rising edge after its index pair is applied. It is computed from the view held before that edge. A pan or zoom pulse therefore changes the outputs one edge later again, for the next index pair. The bench drives every input just after a falling edge. At the following rising edge it computes the expected pair from its own model state and then updates that state. It compares at the next falling edge, so the one-cycle latency and the old-view-versus-new-view ordering are both checked on every cycle. The reset check samples the outputs after the edge on which reset was high.

// File: rtl/pzm_pkg.sv
package pzm_pkg;

    localparam int IDX_W      = 6;
    localparam int COORD_W    = 16;
    localparam int FRAC_W     = 12;
    localparam int BASE_EXP   = 4;                      // step at level 0 is 2^-BASE_EXP
    localparam int LEVEL_MAX  = 8;
    localparam int PAN_EXP    = 3;                      // pan = 2^PAN_EXP pixel steps
    localparam int LEVEL_W    = $clog2(LEVEL_MAX + 1);
    localparam int BASE_SHIFT = FRAC_W - BASE_EXP;
    localparam int HALF_GRID  = 1 << (IDX_W - 1);

    typedef logic signed [COORD_W-1:0] coord_t;
    typedef logic        [LEVEL_W-1:0] level_t;
    typedef logic        [IDX_W-1:0]   pix_t;

    typedef struct packed {
        coord_t ox;
        coord_t oy;
        level_t lvl;
    } view_t;

    function automatic coord_t step_of(level_t l);
        return coord_t'(1) <<< (BASE_SHIFT - int'(l));
    endfunction

    function automatic coord_t pan_of(level_t l);
        return step_of(l) <<< PAN_EXP;
    endfunction

    function automatic coord_t centered(pix_t idx);
        return coord_t'({{(COORD_W-IDX_W){1'b0}}, idx}) - coord_t'(HALF_GRID);
    endfunction

    function automatic coord_t map_axis(coord_t origin, pix_t idx, level_t l);
        return origin + (centered(idx) <<< (BASE_SHIFT - int'(l)));
    endfunction

endpackage

// File: rtl/pzm_view_state.sv
module pzm_view_state
    import pzm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pan_up,
    input  logic  pan_down,
    input  logic  pan_left,
    input  logic  pan_right,
    input  logic  zoom_in,
    input  logic  zoom_out,
    output view_t view_o
);

    view_t  cur;
    view_t  nxt;
    coord_t pan;

    assign pan = pan_of(cur.lvl);

    always_comb begin
        nxt = cur;
        if (pan_right && !pan_left)
            nxt.ox = cur.ox + pan;
        else if (pan_left && !pan_right)
            nxt.ox = cur.ox - pan;

        if (pan_up && !pan_down)
            nxt.oy = cur.oy + pan;
        else if (pan_down && !pan_up)
            nxt.oy = cur.oy - pan;

        if (zoom_in && !zoom_out && (cur.lvl < level_t'(LEVEL_MAX)))
            nxt.lvl = cur.lvl + level_t'(1);
        else if (zoom_out && !zoom_in && (cur.lvl != '0))
            nxt.lvl = cur.lvl - level_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign view_o = cur;

endmodule

// File: rtl/pzm_axis_map.sv
module pzm_axis_map
    import pzm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  coord_t origin,
    input  pix_t   idx,
    input  level_t lvl,
    output coord_t coord_o
);

    always_ff @(posedge clk) begin
        if (rst)
            coord_o <= '0;
        else
            coord_o <= map_axis(origin, idx, lvl);
    end

endmodule

// File: rtl/pan_zoom_mapper.sv
module pan_zoom_mapper
    import pzm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   pix_x,
    input  logic [IDX_W-1:0]   pix_y,
    input  logic               pan_up,
    input  logic               pan_down,
    input  logic               pan_left,
    input  logic               pan_right,
    input  logic               zoom_in,
    input  logic               zoom_out,
    output logic [COORD_W-1:0] re_out,
    output logic [COORD_W-1:0] im_out
);

    localparam int AXES = 2;

    view_t  view_q;
    coord_t org [AXES];
    pix_t   idx [AXES];
    coord_t res [AXES];

    pzm_view_state u_view (
        .clk       (clk),
        .rst       (rst),
        .pan_up    (pan_up),
        .pan_down  (pan_down),
        .pan_left  (pan_left),
        .pan_right (pan_right),
        .zoom_in   (zoom_in),
        .zoom_out  (zoom_out),
        .view_o    (view_q)
    );

    assign org[0] = view_q.ox;
    assign org[1] = view_q.oy;
    assign idx[0] = pix_x;
    assign idx[1] = pix_y;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        pzm_axis_map u_map (
            .clk     (clk),
            .rst     (rst),
            .origin  (org[a]),
            .idx     (idx[a]),
            .lvl     (view_q.lvl),
            .coord_o (res[a])
        );
    end

    assign re_out = res[0];
    assign im_out = res[1];

endmodule

// File: rtl/pzm_checker.sv
module pzm_checker
    import pzm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [IDX_W-1:0]   pix_x,
    input logic [IDX_W-1:0]   pix_y,
    input logic               pan_up,
    input logic               pan_down,
    input logic               pan_left,
    input logic               pan_right,
    input logic               zoom_in,
    input logic               zoom_out,
    input view_t              vw,
    input logic [COORD_W-1:0] re_out,
    input logic [COORD_W-1:0] im_out
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (re_out == '0 && im_out == '0 && vw.lvl == '0)); // R1

    AST_CENTRE_IS_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (pix_x == pix_t'(HALF_GRID) && pix_y == pix_t'(HALF_GRID))
        |=> (re_out == $past(vw.ox) && im_out == $past(vw.oy))); // R2

    AST_ORIGIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pan_up && !pan_down && !pan_left && !pan_right)
        |=> ($stable(vw.ox) && $stable(vw.oy))); // R4

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!zoom_in && !zoom_out) |=> $stable(vw.lvl)); // R5

    AST_LEVEL_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vw.lvl == $past(vw.lvl) || vw.lvl == $past(vw.lvl) + 1'b1
                  || vw.lvl + 1'b1 == $past(vw.lvl))); // R5

    AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        vw.lvl <= level_t'(LEVEL_MAX)); // R6

    AST_TOP_LEVEL_STICKS: assert property (@(posedge clk) disable iff (rst)
        (vw.lvl == level_t'(LEVEL_MAX) && !zoom_out) |=> vw.lvl == level_t'(LEVEL_MAX)); // R6

endmodule

bind pan_zoom_mapper pzm_checker u_pzm_checker (
    .clk       (clk),
    .rst       (rst),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pan_up    (pan_up),
    .pan_down  (pan_down),
    .pan_left  (pan_left),
    .pan_right (pan_right),
    .zoom_in   (zoom_in),
    .zoom_out  (zoom_out),
    .vw        (view_q),
    .re_out    (re_out),
    .im_out    (im_out)
);

// File: tb/test_pan_zoom_mapper.sv
module test_pan_zoom_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  pix_x = '0, pix_y = '0;
    logic        pan_up = 0, pan_down = 0, pan_left = 0, pan_right = 0;
    logic        zoom_in = 0, zoom_out = 0;
    logic [15:0] re_out, im_out;

    int checks = 0;
    int errors = 0;
    int m_ox = 0, m_oy = 0, m_lvl = 0;
    int exp_re = 0, exp_im = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    pan_zoom_mapper i_pan_zoom_mapper (
        .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y),
        .pan_up(pan_up), .pan_down(pan_down), .pan_left(pan_left), .pan_right(pan_right),
        .zoom_in(zoom_in), .zoom_out(zoom_out), .re_out(re_out), .im_out(im_out)
    );

    function automatic int ref_map(int origin, int idx, int lvl);
        return (origin + (idx - 32) * (1 << (8 - lvl))) & 16'hFFFF;
    endfunction

    task automatic check(string tag, int got, int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, want);
        end
    endtask

    // Called at a falling edge: drive, model at rising edge, compare at next falling edge.
    task automatic tick(string tag, bit r, int px, int py,
                        bit u, bit d, bit l, bit rt, bit zi, bit zo);
        int pan;
        rst = r; pix_x = 6'(px); pix_y = 6'(py);
        pan_up = u; pan_down = d; pan_left = l; pan_right = rt;
        zoom_in = zi; zoom_out = zo;
        @(posedge clk);
        if (r) begin
            exp_re = 0; exp_im = 0; m_ox = 0; m_oy = 0; m_lvl = 0;
        end else begin
            exp_re = ref_map(m_ox, px, m_lvl);
            exp_im = ref_map(m_oy, py, m_lvl);
            pan = 1 << (11 - m_lvl);
            if (rt && !l) m_ox = (m_ox + pan) & 16'hFFFF;
            if (l && !rt) m_ox = (m_ox - pan) & 16'hFFFF;
            if (u && !d)  m_oy = (m_oy + pan) & 16'hFFFF;
            if (d && !u)  m_oy = (m_oy - pan) & 16'hFFFF;
            if (zi && !zo && m_lvl < 8) m_lvl++;
            else if (zo && !zi && m_lvl > 0) m_lvl--;
        end
        @(negedge clk);
        check({tag, " re"}, int'(re_out), exp_re);
        check({tag, " im"}, int'(im_out), exp_im);
    endtask

    task automatic idle(string tag, int px, int py);
        tick(tag, 0, px, py, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        tick("R1", 1, 5, 60, 0, 0, 0, 0, 0, 0);
        tick("R1", 1, 0, 0, 1, 0, 0, 1, 1, 0);
        // R3: default span at level 0, origin 0
        idle("R3", 0, 63);
        check("R3 literal low", int'(re_out), 16'hE000);
        check("R3 literal high", int'(im_out), 16'h1F00);
        idle("R3", 32, 32);
        check("R3 literal centre", int'(re_out), 0);
        // R4: pans
        tick("R4", 0, 10, 20, 0, 0, 0, 1, 0, 0);
        tick("R4", 0, 40, 50, 0, 0, 0, 1, 0, 0);
        tick("R4", 0, 32, 32, 1, 0, 1, 0, 0, 0);
        idle("R4", 32, 32);
        check("R4 literal ox", int'(re_out), 16'h0800);
        check("R4 literal oy", int'(im_out), 16'h0800);
        tick("R4", 0, 1, 2, 1, 1, 1, 1, 0, 0);
        tick("R4", 0, 7, 9, 0, 1, 0, 0, 0, 0);
        idle("R4", 32, 32);
        // R5: zoom and opposing zoom
        tick("R5", 0, 0, 63, 0, 0, 0, 0, 1, 0);
        tick("R5", 0, 0, 63, 0, 0, 0, 0, 1, 1);
        tick("R5", 0, 0, 63, 0, 0, 0, 0, 1, 0);
        tick("R5", 0, 0, 63, 0, 0, 0, 0, 0, 1);
        idle("R5", 0, 63);
        // R6: upper and lower limits
        for (int i = 0; i < 11; i++) tick("R6", 0, 33, 31, 0, 0, 0, 0, 1, 0);
        idle("R6", 33, 31);
        check("R6 literal top step", int'(re_out - 16'h0800), 1);
        for (int i = 0; i < 11; i++) tick("R6", 0, 34, 30, 0, 0, 0, 0, 0, 1);
        idle("R6", 34, 30);
        // R7: pan with zoom in same cycle uses old step
        tick("R7", 0, 32, 32, 0, 0, 0, 1, 1, 0);
        tick("R7", 0, 32, 32, 0, 0, 0, 1, 0, 0);
        idle("R7", 32, 32);
        tick("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: wrap of origin and sum
        for (int i = 0; i < 18; i++) tick("R8", 0, 63, 0, 0, 1, 0, 1, 0, 0);
        idle("R8", 63, 0);
        // R2: mixed stimulus
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 99);
            tick("R2", r == 0, $urandom_range(0, 63), $urandom_range(0, 63),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule